// File: doc/BRIEF.md
# Serial Code Receiver and Matcher

This block sits on the lock side of a one-wire optical key. Its input is a digital serial line, already squared up from a light detector. The line rests low. A frame opens with a high start bit, and a fixed number of data bits follow at the same bit rate the key uses. The receiver first re-times the line with a two-flop synchroniser. It takes the low-to-high transition on an idle line as the start of a frame and samples every data bit near the middle of its period. Each sample goes into a shift register, so the serial stream becomes a parallel word again.

After the last data bit is sampled, the parallel word is compared once with a reference code. The compare is per-bit equality: each bit pair is XORed, each result is inverted, and all of them are ANDed. On a match, the unlock output goes high for a set number of clock cycles to drive the solenoid stage. On a mismatch, unlock is forced low and a one-cycle error pulse is raised. The code width, the bit period and the unlock hold time are all parameters, so the code can be widened from 4 to 8 bits by changing one value.

Top module: `serial_lock_rx`

## Requirements
- R1: While reset is asserted and right after it, `unlock` and `mismatch` are 0 and `code_out` is all zeros.
- R2: A frame starts when the line goes from low to high while no frame is in progress. The start bit and each of the CODE_W data bits last BIT_CYCLES clocks. Each data bit is sampled near the middle of its period, measured from the start edge.
- R3: Each sample enters bit 0 of `code_out` while every other bit moves up one place. The first data bit sent therefore ends up in the most significant bit, so a frame sent as 1,0,1,0 yields 4'b1010. Outside a frame, `code_out` does not change.
- R4: The compare is made only once all CODE_W data bits have arrived. While a frame is still incomplete, neither `unlock` nor `mismatch` changes.
- R5: If the received word equals `ref_code` in every bit, `unlock` rises one clock after the last sample and stays high for exactly HOLD_CYCLES clocks.
- R6: If the received word differs from `ref_code` in any single bit position, `unlock` stays low and `mismatch` is high for exactly one clock.
- R7: A matching frame that completes while `unlock` is high restarts the hold window without a gap, so `unlock` stays high for HOLD_CYCLES clocks after the second compare.
- R8: A mismatching frame that completes while `unlock` is high drops `unlock` one clock after its last sample.
- R9: Asserting `rst_n` low at any time clears `unlock`, `code_out` and the frame state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_in | input | 1 | Serial line from the detector, idle low |
| ref_code | input | CODE_W | Stored reference code |
| code_out | output | CODE_W | Most recently received parallel word |
| unlock | output | 1 | High for the hold window after a matching frame |
| mismatch | output | 1 | One-cycle pulse after a non-matching frame |

## Verification
The matching pattern 1010 shows that the bits are sampled at the right points. The non-matching pattern 0011 shows the shift order, because `code_out` is read back and 0011 differs from its own bit reversal. Four frames, each differing from the reference in one bit, show that every bit position takes part in the compare. Further frames test the rest. A frame is paused part-way through to check that no compare happens early. Two matches sent back to back, and a match followed by a miss, show how the hold timer restarts and how unlock is dropped. A reset in the middle of the hold window checks the asynchronous clear.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_DATA = 1'b1
  } rx_state_e;
endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lock_frame_rx.sv
module lock_frame_rx
  import lock_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(BIT_CYCLES + BIT_CYCLES/2 + 1);
  localparam int NB_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [CNT_W-1:0] FIRST_WAIT = CNT_W'(BIT_CYCLES + BIT_CYCLES/2 - 1);
  localparam logic [CNT_W-1:0] BIT_WAIT   = CNT_W'(BIT_CYCLES - 1);
  localparam logic [NB_W-1:0]  LAST_BIT   = NB_W'(CODE_W - 1);

  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [NB_W-1:0]   nbit_q, nbit_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic              done_q, done_n;
  logic              line_d_q;
  logic              rise_c;

  assign rise_c = line_i & ~line_d_q;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    nbit_n  = nbit_q;
    code_n  = code_q;
    done_n  = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (rise_c) begin
          state_n = RX_DATA;
          cnt_n   = FIRST_WAIT;
          nbit_n  = '0;
        end
      end
      RX_DATA: begin
        if (cnt_q == '0) begin
          code_n = {code_q[CODE_W-2:0], line_i};
          cnt_n  = BIT_WAIT;
          if (nbit_q == LAST_BIT) begin
            done_n  = 1'b1;
            state_n = RX_IDLE;
          end else begin
            nbit_n = nbit_q + 1'b1;
          end
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: state_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      nbit_q   <= '0;
      code_q   <= '0;
      done_q   <= 1'b0;
      line_d_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      nbit_q   <= nbit_n;
      code_q   <= code_n;
      done_q   <= done_n;
      line_d_q <= line_i;
    end
  end

  assign code_o = code_q;
  assign done_o = done_q;

  AST_IDLE_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE) |=> $stable(code_q)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R4
  AST_DONE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(state_q == RX_DATA)); // R4
endmodule

// File: rtl/lock_match.sv
module lock_match #(
  parameter int CODE_W      = 4,
  parameter int HOLD_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] ref_i,
  output logic              unlock_o,
  output logic              err_o
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES - 1);

  logic [CODE_W-1:0] same_bits;
  logic              match_c;
  logic [HOLD_W-1:0] hold_q, hold_n;
  logic              unlock_q, unlock_n;
  logic              err_q, err_n;

  for (genvar i = 0; i < CODE_W; i++) begin : g_bit_eq
    assign same_bits[i] = ~(code_i[i] ^ ref_i[i]);
  end
  assign match_c = &same_bits;

  always_comb begin
    hold_n   = hold_q;
    unlock_n = unlock_q;
    err_n    = 1'b0;
    if (done_i) begin
      if (match_c) begin
        unlock_n = 1'b1;
        hold_n   = HOLD_LOAD;
      end else begin
        unlock_n = 1'b0;
        hold_n   = '0;
        err_n    = 1'b1;
      end
    end else if (unlock_q) begin
      if (hold_q == '0) unlock_n = 1'b0;
      else              hold_n   = hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      unlock_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      hold_q   <= hold_n;
      unlock_q <= unlock_n;
      err_q    <= err_n;
    end
  end

  assign unlock_o = unlock_q;
  assign err_o    = err_q;

  AST_UNLOCK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_q) |-> $past(done_i && (code_i == ref_i))); // R5
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q); // R6
  AST_ERR_KEEPS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !unlock_q); // R6
  AST_MISS_DROPS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && (code_i != ref_i)) |=> !unlock_q); // R8
  AST_HIT_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && (code_i == ref_i)) |=> unlock_q); // R7
  AST_HOLD_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_q && hold_q == '0 && !done_i) |=> !unlock_q); // R5
endmodule

// File: rtl/serial_lock_rx.sv
module serial_lock_rx #(
  parameter int CODE_W      = 4,
  parameter int BIT_CYCLES  = 16,
  parameter int HOLD_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic [CODE_W-1:0] ref_code,
  output logic [CODE_W-1:0] code_out,
  output logic              unlock,
  output logic              mismatch
);
  logic              line_s;
  logic              frame_done;
  logic [CODE_W-1:0] rx_word;

  lock_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ser_in),
    .q_o   (line_s)
  );

  lock_frame_rx #(.CODE_W(CODE_W), .BIT_CYCLES(BIT_CYCLES)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_s),
    .code_o (rx_word),
    .done_o (frame_done)
  );

  lock_match #(.CODE_W(CODE_W), .HOLD_CYCLES(HOLD_CYCLES)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_i   (frame_done),
    .code_i   (rx_word),
    .ref_i    (ref_code),
    .unlock_o (unlock),
    .err_o    (mismatch)
  );

  assign code_out = rx_word;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unlock, mismatch})); // R6
endmodule

// File: tb/serial_lock_rx_test.sv
module serial_lock_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 4;
  localparam int BITC       = 16;
  localparam int HOLD       = 100;
  localparam int GAP        = 4;
  localparam int FRAME_LEN  = (CODE_W + 1) * BITC + GAP;

  logic              clk;
  logic              rst_n;
  logic              ser_in;
  logic [CODE_W-1:0] ref_code;
  logic [CODE_W-1:0] code_out;
  logic              unlock;
  logic              mismatch;

  int checks;
  int failures;
  int unlock_rises;
  int run_len;
  int last_run;
  int err_cycles;
  int err_rises;
  logic unlock_prev;
  logic err_prev;

  serial_lock_rx #(.CODE_W(CODE_W), .BIT_CYCLES(BITC), .HOLD_CYCLES(HOLD)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_in   (ser_in),
    .ref_code (ref_code),
    .code_out (code_out),
    .unlock   (unlock),
    .mismatch (mismatch)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      run_len     = 0;
      unlock_prev = 1'b0;
      err_prev    = 1'b0;
    end else begin
      if (unlock) begin
        run_len = run_len + 1;
        if (!unlock_prev) unlock_rises = unlock_rises + 1;
      end else if (run_len != 0) begin
        last_run = run_len;
        run_len  = 0;
      end
      if (mismatch) begin
        err_cycles = err_cycles + 1;
        if (!err_prev) err_rises = err_rises + 1;
      end
      unlock_prev = unlock;
      err_prev    = mismatch;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [CODE_W-1:0] code, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      ser_in = code[CODE_W-1-i];
      repeat (BITC) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [CODE_W-1:0] code);
    ser_in = 1'b1;
    repeat (BITC) @(negedge clk);
    send_bits(code, 0, CODE_W-1);
    ser_in = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic do_reset();
    ser_in = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 unlock after reset", unlock, 0);
    chk("R1 mismatch after reset", mismatch, 0);
    chk("R1 code_out after reset", code_out, 0);
  endtask

  task automatic t_match();
    int r0;
    r0 = unlock_rises;
    ref_code = 4'b1010;
    send_frame(4'b1010);
    chk("R2 sampled word 1010", code_out, 4'b1010);
    chk("R5 unlock high after match", unlock, 1);
    chk("R5 one unlock rise", unlock_rises - r0, 1);
    repeat (HOLD + 10) @(negedge clk);
    chk("R5 unlock window length", last_run, HOLD);
    chk("R5 unlock low after window", unlock, 0);
  endtask

  task automatic t_order();
    int e0;
    int c0;
    e0 = err_rises;
    c0 = err_cycles;
    ref_code = 4'b1010;
    send_frame(4'b0011);
    chk("R3 shift order gives 0011", code_out, 4'b0011);
    chk("R6 unlock stays low on miss", unlock, 0);
    chk("R6 one mismatch pulse", err_rises - e0, 1);
    chk("R6 mismatch lasts one cycle", err_cycles - c0, 1);
  endtask

  task automatic t_single_bit();
    for (int b = 0; b < CODE_W; b++) begin
      int e0;
      int r0;
      e0 = err_rises;
      r0 = unlock_rises;
      ref_code = 4'b0110;
      send_frame(4'b0110 ^ (4'b0001 << b));
      repeat (2) @(negedge clk);
      chk("R6 single bit miss no unlock", unlock_rises - r0, 0);
      chk("R6 single bit miss pulse", err_rises - e0, 1);
    end
  endtask

  task automatic t_partial();
    int e0;
    int r0;
    e0 = err_rises;
    r0 = unlock_rises;
    ref_code = 4'b1100;
    ser_in = 1'b1;
    repeat (BITC) @(negedge clk);
    send_bits(4'b1100, 0, 1);
    chk("R4 no unlock mid frame", unlock_rises - r0, 0);
    chk("R4 no mismatch mid frame", err_rises - e0, 0);
    send_bits(4'b1100, 2, CODE_W-1);
    ser_in = 1'b0;
    repeat (GAP) @(negedge clk);
    chk("R4 unlock after last bit", unlock, 1);
    chk("R4 word after completion", code_out, 4'b1100);
    repeat (HOLD + 10) @(negedge clk);
  endtask

  task automatic t_retrigger();
    int r0;
    r0 = unlock_rises;
    ref_code = 4'b1001;
    send_frame(4'b1001);
    send_frame(4'b1001);
    chk("R7 unlock held across retrigger", unlock_rises - r0, 1);
    repeat (HOLD + 10) @(negedge clk);
    chk("R7 extended window length", last_run, FRAME_LEN + HOLD);
  endtask

  task automatic t_drop();
    int e0;
    ref_code = 4'b0101;
    send_frame(4'b0101);
    e0 = err_rises;
    send_frame(4'b0100);
    chk("R8 unlock dropped by miss", unlock, 0);
    chk("R8 window cut at miss", last_run, FRAME_LEN);
    chk("R8 mismatch pulse on drop", err_rises - e0, 1);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset_mid();
    ref_code = 4'b1111;
    send_frame(4'b1111);
    chk("R9 unlock before reset", unlock, 1);
    rst_n = 1'b0;
    #1;
    chk("R9 unlock cleared by reset", unlock, 0);
    chk("R9 code cleared by reset", code_out, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (HOLD + 5) @(negedge clk);
    chk("R9 stays locked after reset", unlock, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    unlock_rises = 0; run_len = 0; last_run = 0;
    err_cycles = 0; err_rises = 0;
    unlock_prev = 1'b0; err_prev = 1'b0;
    ref_code = '0;
    ser_in = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    t_reset();
    t_match();
    t_order();
    t_single_bit();
    t_partial();
    t_retrigger();
    t_drop();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule